// File: doc/BRIEF.md
# Lane PLL Divider Search Engine

This engine picks the reference pre-divider N and the feedback multiplier M for the PLL that clocks a serial display link. On a start pulse it takes a pixel clock in Hz, a lane count and a pixel format code. From these it derives the lane bit rate the link needs, including a 25% margin over the raw pixel bandwidth. It then walks every pre-divider that keeps the phase-detector input frequency between 5 and 40 MHz. For each one it forms an even multiplier, drops candidates whose multiplier or VCO frequency falls outside the legal ranges, and keeps the candidate whose VCO frequency lies closest to the target.

All divisions run through one shared restoring divider that produces one quotient bit per cycle. Each pre-divider step therefore takes one or two divider passes. The result is N, M and the VCO rate that will actually be achieved, flagged as valid or as an error. A single-cycle done pulse marks the end of the search.

Top module: `pll_lane_search`

## Requirements
- R1: The bits per pixel come from `fmt_i`. Codes 0 and 1 give 24, code 2 gives 18 and code 3 gives 16.
- R2: A format code of 4 to 7 ends the search with `err_o` set.
- R3: A lane count of zero ends the search with `err_o` set.
- R4: The target rate is floor(floor(floor(pclk / lanes) × bpp) / 8) × 10, in Hz.
- R5: A target of 1 500 000 000 Hz or more ends the search with `err_o` set, and no candidate is tried.
- R6: The pre-divider N runs upward from ceil(FREF_HZ / 40 MHz) to floor(FREF_HZ / 5 MHz). With the default 24 MHz reference this is 1 to 4.
- R7: For each N, M is floor(target × N / FREF_HZ), plus one if that value is odd. A candidate with M below 6 or above 512 is dropped.
- R8: The achieved rate is floor(M × FREF_HZ / N). A candidate whose rate lies below 80 MHz or above 1500 MHz is dropped.
- R9: The winner has the smallest absolute difference between rate and target. The comparison starts from a 1500 MHz bound, and only a strictly smaller difference replaces the current best, so the lowest N wins a tie.
- R10: When no candidate survives, the search ends with `err_o` set. On any error, `n_o`, `m_o` and `rate_o` read zero.
- R11: `done_o` is high for exactly one cycle at the end of a search. `valid_o` and `err_o` are never high together. `busy_o` is high for the whole search. A start pulse that arrives while the engine is busy is ignored. The results hold until the next accepted start.
- R12: After reset, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when the engine is idle |
| pclk_hz_i | input | PCLK_W | Pixel clock in Hz |
| lanes_i | input | LANE_W | Number of data lanes |
| fmt_i | input | 3 | Pixel format code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| valid_o | output | 1 | A legal divider pair was found |
| err_o | output | 1 | Bad input, target too high, or no legal pair |
| n_o | output | N_W | Chosen pre-divider |
| m_o | output | M_W | Chosen feedback multiplier |
| rate_o | output | W | Achieved VCO rate in Hz |

## Verification
The assertions assume two things about the block's setup. First, the reference and window parameters give a non-empty N range. Second, a start pulse while busy is the only way inputs can change in the middle of a search; these inputs are sampled once when a search is accepted. The stimulus uses the default 24 MHz reference and holds each input steady around its start pulse. It mixes random pixel clocks from 20 to 300 MHz across all lane counts and valid formats with directed points: an illegal format, zero lanes, a target exactly at the 1500 MHz limit and just below it, a target too low for any multiplier, an all-way tie, and a start pulse that arrives during a search.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TGT,
    S_MSTART,
    S_MWAIT,
    S_FWAIT,
    S_FIN
  } srch_state_e;

  // bits per pixel for a format code, 0 for an unknown code
  function automatic logic [4:0] fmt_bpp(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: fmt_bpp = 5'd24;
      3'd2:       fmt_bpp = 5'd18;
      3'd3:       fmt_bpp = 5'd16;
      default:    fmt_bpp = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= dividend_i;
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= fits ? W'(trial - {1'b0, dvs_q}) : trial[W-1:0];
      quo_q  <= {quo_q[W-2:0], fits};
      cnt_q  <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/pll_tgt_calc.sv
module pll_tgt_calc #(
  parameter int W = 64
) (
  input  logic [W-1:0] per_lane_i,
  input  logic [4:0]   bpp_i,
  output logic [W-1:0] target_o
);
  logic [W-1:0] bits_w, bytes_w;

  assign bits_w   = per_lane_i * W'(bpp_i);
  assign bytes_w  = bits_w >> 3;
  // x10 as x8 + x2
  assign target_o = (bytes_w << 3) + (bytes_w << 1);
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int              W          = 64,
  parameter longint unsigned M_MIN      = 6,
  parameter longint unsigned M_MAX      = 512,
  parameter longint unsigned VCO_MIN_HZ = 80_000_000,
  parameter longint unsigned VCO_MAX_HZ = 1_500_000_000
) (
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] best_delta_i,
  output logic [W-1:0] m_even_o,
  output logic         m_ok_o,
  output logic         vco_ok_o,
  output logic [W-1:0] delta_o,
  output logic         better_o
);
  assign m_even_o = quo_i + W'(quo_i[0]);
  assign m_ok_o   = (m_even_o >= M_MIN) && (m_even_o <= M_MAX);
  assign vco_ok_o = (quo_i >= VCO_MIN_HZ) && (quo_i <= VCO_MAX_HZ);
  assign delta_o  = (quo_i > target_i) ? quo_i - target_i : target_i - quo_i;
  assign better_o = delta_o < best_delta_i;
endmodule

// File: rtl/pll_lane_search.sv
module pll_lane_search
  import pll_srch_pkg::*;
#(
  parameter int              W           = 64,
  parameter int              PCLK_W      = 32,
  parameter int              LANE_W      = 3,
  parameter int              N_W         = 8,
  parameter int              M_W         = 10,
  parameter longint unsigned FREF_HZ     = 24_000_000,
  parameter longint unsigned PFD_MIN_HZ  = 5_000_000,
  parameter longint unsigned PFD_MAX_HZ  = 40_000_000,
  parameter longint unsigned LANE_MAX_HZ = 1_500_000_000,
  parameter longint unsigned VCO_MIN_HZ  = 80_000_000,
  parameter longint unsigned VCO_MAX_HZ  = 1_500_000_000,
  parameter longint unsigned M_MIN       = 6,
  parameter longint unsigned M_MAX       = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PCLK_W-1:0] pclk_hz_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic [2:0]        fmt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic [W-1:0]      rate_o
);
  localparam logic [N_W-1:0] N_LO = N_W'((FREF_HZ + PFD_MAX_HZ - 1) / PFD_MAX_HZ);
  localparam logic [N_W-1:0] N_HI = N_W'(FREF_HZ / PFD_MIN_HZ);

  srch_state_e    state_q;
  logic [4:0]     bpp_q;
  logic [W-1:0]   target_q, best_delta_q, best_rate_q;
  logic [N_W-1:0] n_q, best_n_q;
  logic [M_W-1:0] m_q, best_m_q;
  logic           found_q, done_q, valid_q, err_q;

  logic           div_start, div_done;
  logic [W-1:0]   div_dividend, div_divisor, div_quot;
  logic [W-1:0]   tgt_w, m_even, delta;
  logic           m_ok, vco_ok, better;
  logic           in_ok, step_done, last_n;

  pll_rdiv #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  pll_tgt_calc #(.W(W)) u_tgt (
    .per_lane_i (div_quot),
    .bpp_i      (bpp_q),
    .target_o   (tgt_w)
  );

  pll_cand_eval #(
    .W(W), .M_MIN(M_MIN), .M_MAX(M_MAX),
    .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ)
  ) u_eval (
    .quo_i        (div_quot),
    .target_i     (target_q),
    .best_delta_i (best_delta_q),
    .m_even_o     (m_even),
    .m_ok_o       (m_ok),
    .vco_ok_o     (vco_ok),
    .delta_o      (delta),
    .better_o     (better)
  );

  assign in_ok     = (fmt_bpp(fmt_i) != 5'd0) && (lanes_i != '0);
  assign step_done = ((state_q == S_MWAIT) && div_done && !m_ok) ||
                     ((state_q == S_FWAIT) && div_done);
  assign last_n    = (n_q == N_HI);

  // divider operand mux
  always_comb begin
    div_start    = 1'b0;
    div_dividend = '0;
    div_divisor  = W'(1);
    case (state_q)
      S_IDLE: if (start_i && in_ok) begin
        div_start    = 1'b1;
        div_dividend = W'(pclk_hz_i);
        div_divisor  = W'(lanes_i);
      end
      S_MSTART: begin
        div_start    = 1'b1;
        div_dividend = target_q * W'(n_q);
        div_divisor  = W'(FREF_HZ);
      end
      S_MWAIT: if (div_done && m_ok) begin
        div_start    = 1'b1;
        div_dividend = W'(m_even * FREF_HZ);
        div_divisor  = W'(n_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      bpp_q        <= '0;
      target_q     <= '0;
      best_delta_q <= '0;
      best_rate_q  <= '0;
      n_q          <= '0;
      best_n_q     <= '0;
      m_q          <= '0;
      best_m_q     <= '0;
      found_q      <= 1'b0;
      done_q       <= 1'b0;
      valid_q      <= 1'b0;
      err_q        <= 1'b0;
      n_o          <= '0;
      m_o          <= '0;
      rate_o       <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          valid_q     <= 1'b0;
          err_q       <= 1'b0;
          n_o         <= '0;
          m_o         <= '0;
          rate_o      <= '0;
          found_q     <= 1'b0;
          best_n_q    <= '0;
          best_m_q    <= '0;
          best_rate_q <= '0;
          bpp_q       <= fmt_bpp(fmt_i);
          state_q     <= in_ok ? S_TGT : S_FIN;
        end
        S_TGT: if (div_done) begin
          target_q     <= tgt_w;
          n_q          <= N_LO;
          best_delta_q <= W'(VCO_MAX_HZ);
          state_q      <= (tgt_w >= LANE_MAX_HZ) ? S_FIN : S_MSTART;
        end
        S_MSTART: state_q <= S_MWAIT;
        S_MWAIT: if (div_done) begin
          m_q <= m_even[M_W-1:0];
          if (m_ok) state_q <= S_FWAIT;
        end
        S_FWAIT: if (div_done && vco_ok && better) begin
          best_delta_q <= delta;
          best_rate_q  <= div_quot;
          best_n_q     <= n_q;
          best_m_q     <= m_q;
          found_q      <= 1'b1;
        end
        S_FIN: begin
          done_q  <= 1'b1;
          valid_q <= found_q;
          err_q   <= !found_q;
          n_o     <= best_n_q;
          m_o     <= best_m_q;
          rate_o  <= best_rate_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
      if (step_done) begin
        if (last_n) begin
          state_q <= S_FIN;
        end else begin
          n_q     <= n_q + N_W'(1);
          state_q <= S_MSTART;
        end
      end
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pll_srch_chk.sv
module pll_srch_chk #(
  parameter int              W          = 64,
  parameter int              N_W        = 8,
  parameter int              M_W        = 10,
  parameter longint unsigned FREF_HZ    = 24_000_000,
  parameter longint unsigned PFD_MIN_HZ = 5_000_000,
  parameter longint unsigned PFD_MAX_HZ = 40_000_000,
  parameter longint unsigned VCO_MIN_HZ = 80_000_000,
  parameter longint unsigned VCO_MAX_HZ = 1_500_000_000,
  parameter longint unsigned M_MIN      = 6,
  parameter longint unsigned M_MAX      = 512
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           valid_o,
  input logic           err_o,
  input logic [N_W-1:0] n_o,
  input logic [M_W-1:0] m_o,
  input logic [W-1:0]   rate_o
);
  localparam longint unsigned CK_N_LO = (FREF_HZ + PFD_MAX_HZ - 1) / PFD_MAX_HZ;
  localparam longint unsigned CK_N_HI = FREF_HZ / PFD_MIN_HZ;

  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  a_r11_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i)) |->
      ($stable(rate_o) && $stable(n_o) && $stable(m_o) && $stable(valid_o)));

  a_r6_n_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (64'(n_o) >= CK_N_LO && 64'(n_o) <= CK_N_HI));

  a_r7_m_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (!m_o[0] && 64'(m_o) >= M_MIN && 64'(m_o) <= M_MAX));

  a_r8_rate_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> (rate_o >= VCO_MIN_HZ && rate_o <= VCO_MAX_HZ));

  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (n_o == '0 && m_o == '0 && rate_o == '0));
endmodule

bind pll_lane_search pll_srch_chk #(
  .W(W), .N_W(N_W), .M_W(M_W), .FREF_HZ(FREF_HZ),
  .PFD_MIN_HZ(PFD_MIN_HZ), .PFD_MAX_HZ(PFD_MAX_HZ),
  .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ),
  .M_MIN(M_MIN), .M_MAX(M_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .valid_o(valid_o), .err_o(err_o),
  .n_o(n_o), .m_o(m_o), .rate_o(rate_o)
);

// File: tb/pll_lane_search_bench.sv
module pll_lane_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned FREF = 24_000_000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] pclk_hz_i = '0;
  logic [2:0]  lanes_i = '0;
  logic [2:0]  fmt_i = '0;
  logic        busy_o, done_o, valid_o, err_o;
  logic [7:0]  n_o;
  logic [9:0]  m_o;
  logic [63:0] rate_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pll_lane_search u_pll_lane_search (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .pclk_hz_i(pclk_hz_i), .lanes_i(lanes_i), .fmt_i(fmt_i),
    .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o), .err_o(err_o),
    .n_o(n_o), .m_o(m_o), .rate_o(rate_o)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference search from the requirements
  task automatic model(input longint unsigned pclk, input int lanes, input int fmt,
                       output bit ok, output longint unsigned en,
                       output longint unsigned em, output longint unsigned er);
    longint unsigned bpp, tgt, best;
    ok = 0; en = 0; em = 0; er = 0;
    case (fmt)
      0, 1: bpp = 24;
      2: bpp = 18;
      3: bpp = 16;
      default: bpp = 0;
    endcase
    if (bpp == 0 || lanes == 0) return;
    tgt = ((pclk / lanes) * bpp / 8) * 10;
    if (tgt >= 64'd1_500_000_000) return;
    best = 64'd1_500_000_000;
    for (longint unsigned n = (FREF + 39_999_999) / 40_000_000; n <= FREF / 5_000_000; n++) begin
      longint unsigned mm, f, d;
      mm = tgt * n / FREF;
      mm = mm + (mm % 2);
      if (mm < 6 || mm > 512) continue;
      f = mm * FREF / n;
      if (f < 80_000_000 || f > 64'd1_500_000_000) continue;
      d = (f > tgt) ? f - tgt : tgt - f;
      if (d < best) begin
        best = d; ok = 1; en = n; em = mm; er = f;
      end
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (done_o) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic run_case(input string req, input longint unsigned pclk,
                          input int lanes, input int fmt, input bit mid_start);
    bit ok, seen;
    longint unsigned en, em, er;
    model(pclk, lanes, fmt, ok, en, em, er);
    @(negedge clk_i);
    pclk_hz_i = 32'(pclk); lanes_i = 3'(lanes); fmt_i = 3'(fmt); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (mid_start) begin
      repeat (5) @(negedge clk_i);
      // R11: start while busy must be ignored
      pclk_hz_i = 32'd20_000_000; lanes_i = 3'd1; fmt_i = 3'd3; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    wait_done(seen);
    chk({req, " done seen"}, 64'(seen), 1);
    if (!seen) return;
    chk({req, " valid,err"}, {62'd0, valid_o, err_o}, ok ? 64'd2 : 64'd1);
    chk({req, " n"}, 64'(n_o), en);
    chk({req, " m"}, 64'(m_o), em);
    chk({req, " rate"}, rate_o, er);
    @(negedge clk_i);
    chk({req, " R11 done one cycle"}, 64'(done_o), 0);
    repeat (3) @(negedge clk_i);
    chk({req, " R11 rate held"}, rate_o, er);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk("R12 busy", 64'(busy_o), 0);
    chk("R12 done", 64'(done_o), 0);
    chk("R12 flags", {62'd0, valid_o, err_o}, 0);
    chk("R12 rate", rate_o, 0);
    chk("R12 n,m", {46'd0, n_o, m_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_case("R4 R9 148.5M x4 rgb888", 148_500_000, 4, 0, 0);
    chk("R9 expected n literal", 64'(n_o), 4);
    chk("R7 expected m literal", 64'(m_o), 186);
    chk("R8 expected rate literal", rate_o, 64'd1_116_000_000);
    run_case("R9 tie lowest n", 55_200_000, 1, 3, 0);
    chk("R9 tie n literal", 64'(n_o), 1);
    run_case("R2 bad format", 100_000_000, 2, 5, 0);
    run_case("R2 bad format 7", 100_000_000, 2, 7, 0);
    run_case("R3 zero lanes", 100_000_000, 0, 0, 0);
    run_case("R5 target at limit", 50_000_000, 1, 0, 0);
    run_case("R5 just below limit", 49_999_999, 1, 0, 0);
    run_case("R5 far above", 400_000_000, 1, 0, 0);
    run_case("R10 target too low", 1_000_000, 4, 3, 0);
    run_case("R1 format 1 like 0", 120_000_000, 3, 1, 0);
    run_case("R1 format 2", 120_000_000, 3, 2, 0);
    run_case("R11 start while busy", 148_500_000, 4, 0, 1);

    for (int k = 0; k < 24; k++) begin
      longint unsigned p;
      int l, f;
      p = 64'($urandom_range(300_000_000, 20_000_000));
      l = int'($urandom_range(4, 1));
      f = int'($urandom_range(3, 0));
      run_case("R6 R7 R8 R9 random", p, l, f, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule